// File: doc/BRIEF.md
# Up/Down Binary Counter with Direction Priority

This block is a synchronous binary counter, four bits wide by default, that a controller steps forward or backward with two separate command lines. One line asks for an upward count and the other for a downward count. If neither is raised, the value holds. If both are raised, the upward request wins. Every flip-flop shares one clock, and all state changes happen on its rising edge.

The next value does not come from an adder. A per-bit toggle rule produces it instead. The least significant bit flips on every active step. Each higher bit flips only when every bit below it is 1 (counting up) or every bit below it is 0 (counting down). The count wraps at both ends of its range. A synchronous active-high reset returns the count to zero.

Top module: `udc_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, `count` becomes 0000 after that edge and stays 0000 for as long as `rst` stays 1, whatever the command inputs are.
- R2: With `up_cmd`=1 and `dn_cmd`=0 at a rising edge, `count` becomes the previous value plus one after that edge.
- R3: With `up_cmd`=0 and `dn_cmd`=0 at a rising edge, `count` keeps its previous value.
- R4: With `up_cmd`=0 and `dn_cmd`=1 at a rising edge, `count` becomes the previous value minus one after that edge.
- R5: With both `up_cmd`=1 and `dn_cmd`=1, the counter steps upward exactly as in R2.
- R6: An upward step from 1111 gives 0000.
- R7: A downward step from 0000 gives 1111.
- R8: On any active step, bit 0 flips. A higher bit i flips only when bits i-1..0 are all 1 (upward) or all 0 (downward); otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to zero |
| up_cmd | input | 1 | Upward count request; has priority over `dn_cmd` |
| dn_cmd | input | 1 | Downward count request |
| count | output | WIDTH (4) | Registered counter value |

## Verification
The count is a registered output, so a wrong toggle condition shows at `count` on the first rising edge after the bad decision. A failure in one carry chain only appears when the bits below it reach all ones or all zeros. Because of that, the bench walks both wrap points and long runs in one direction, so every bit's toggle edge gets used in both directions. A priority fault only appears when both commands are raised together, and a hold fault shows as any change while both commands are low. The random command mix is there to expose both of these.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;
endpackage

// File: rtl/udc_dir_decode.sv
module udc_dir_decode
  import udc_pkg::*;
(
  input  logic up_cmd,
  input  logic dn_cmd,
  output dir_e dir
);
  // Upward request wins when both lines are raised.
  always_comb begin
    if (up_cmd)      dir = DIR_UP;
    else if (dn_cmd) dir = DIR_DOWN;
    else             dir = DIR_HOLD;
  end
endmodule

// File: rtl/udc_next_state.sv
module udc_next_state
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  output logic [WIDTH-1:0] nxt
);
  // ones_below[i]: bits i-1..0 are all 1; zeros_below[i]: all 0.
  logic [WIDTH-1:0] ones_below;
  logic [WIDTH-1:0] zeros_below;
  logic [WIDTH-1:0] flip;

  assign ones_below[0]  = 1'b1;
  assign zeros_below[0] = 1'b1;

  genvar i;
  generate
    for (i = 1; i < WIDTH; i++) begin : g_chain
      assign ones_below[i]  = ones_below[i-1]  &  cur[i-1];
      assign zeros_below[i] = zeros_below[i-1] & ~cur[i-1];
    end
    for (i = 0; i < WIDTH; i++) begin : g_flip
      assign flip[i] = ((dir == DIR_UP)   && ones_below[i]) ||
                       ((dir == DIR_DOWN) && zeros_below[i]);
    end
  endgenerate

  assign nxt = cur ^ flip;
endmodule

// File: rtl/udc_counter.sv
module udc_counter
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_cmd,
  input  logic             dn_cmd,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  dir_e             dir;
  logic [WIDTH-1:0] count_nxt;

  udc_dir_decode u_dec (
    .up_cmd (up_cmd),
    .dn_cmd (dn_cmd),
    .dir    (dir)
  );

  udc_next_state #(.WIDTH(WIDTH)) u_nxt (
    .cur (count),
    .dir (dir),
    .nxt (count_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) count <= ZERO;
    else     count <= count_nxt;
  end

  // R1: reset forces zero on the following edge
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (count == ZERO));

  // R2 / R6: upward step adds one, wrapping at the top
  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    (up_cmd && !dn_cmd) |=> (count == $past(count) + ONE));

  // R3: no command means no change
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!up_cmd && !dn_cmd) |=> $stable(count));

  // R4 / R7: downward step subtracts one, wrapping at the bottom
  p_down_step_r4: assert property (@(posedge clk) disable iff (rst)
    (dn_cmd && !up_cmd) |=> (count == $past(count) - ONE));

  // R5: both commands behave as upward
  p_both_up_r5: assert property (@(posedge clk) disable iff (rst)
    (up_cmd && dn_cmd) |=> (count == $past(count) + ONE));

  // R8: any active step flips the least significant bit
  p_lsb_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (up_cmd || dn_cmd) |=> (count[0] != $past(count[0])));
endmodule

// File: tb/tb_udc_counter.sv
`timescale 1ns/1ps
module tb_udc_counter;
  localparam int WIDTH = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             up_cmd = 1'b0;
  logic             dn_cmd = 1'b0;
  logic [WIDTH-1:0] count;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  udc_counter #(.WIDTH(WIDTH)) dut (
    .clk    (clk),
    .rst    (rst),
    .up_cmd (up_cmd),
    .dn_cmd (dn_cmd),
    .count  (count)
  );

  // Model built from the bit-toggle rule (R8), independent of arithmetic.
  function automatic logic [WIDTH-1:0] model_next(
      input logic [WIDTH-1:0] c, input logic u, input logic d, input logic r);
    logic [WIDTH-1:0] n;
    logic run;
    if (r) return '0;
    if (!u && !d) return c;
    n = c;
    run = 1'b1;
    for (int b = 0; b < WIDTH; b++) begin
      if (run) n[b] = ~c[b];
      run = run && (u ? c[b] : ~c[b]);
    end
    return n;
  endfunction

  function automatic string tag_of(input logic u, input logic d, input logic r,
                                   input logic [WIDTH-1:0] c);
    if (r) return "R1";
    if (u && d) return "R5";
    if (u) return (c == '1) ? "R6" : "R2";
    if (d) return (c == '0) ? "R7" : "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [WIDTH-1:0] expv);
    checks++;
    if (count !== expv) begin
      errors++;
      $display("FAIL %s: count=%b expected=%b", tag, count, expv);
    end
  endtask

  // Drive away from the edge, update model, sample 1 ns after the edge.
  task automatic step(input logic u, input logic d, input logic r);
    string tag;
    @(negedge clk);
    up_cmd = u; dn_cmd = d; rst = r;
    tag = tag_of(u, d, r, exp_cnt);
    exp_cnt = model_next(exp_cnt, u, d, r);
    @(posedge clk);
    #1;
    check(tag, exp_cnt);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    // R1: reset holds zero even with commands raised
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    // R2, R6, R8: full upward sweep through the wrap
    for (int k = 0; k < 18; k++) step(1'b1, 1'b0, 1'b0);
    // R3: hold at a non-zero value
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0);
    // R4, R7, R8: full downward sweep through the wrap
    for (int k = 0; k < 20; k++) step(1'b0, 1'b1, 1'b0);
    // R5: both raised counts up, including across the top
    for (int k = 0; k < 17; k++) step(1'b1, 1'b1, 1'b0);
    // R7 from reset value directly
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    // Random mix of commands with rare resets
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[0], rv[1], (rv[15:8] == 8'd0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule